// File: doc/BRIEF.md
# Retransmitting Checked Flit Link

This block is both ends of a point-to-point on-chip link that protects each flit with a check byte and repairs errors by resending. On the sending side, a payload word is accepted through a valid/ready handshake. The check byte is added to it, and the whole flit is kept in a hold register. The flit is then driven onto a channel word for exactly one cycle. The receiving side registers the channel word, computes the check byte again over the received payload, and compares it with the received check byte. A match delivers the payload and returns an acknowledge. A mismatch delivers nothing and returns a resend request.

The check code uses the generator x^8+1, so the check byte is the bitwise XOR of the four payload bytes, computed in parallel within one cycle. The receiver only detects errors and never corrects them. The sender resends the held flit after every resend request, with no limit, and takes no new payload until the flit is acknowledged. The channel leaves the block as an output port and comes back as an input port, so a system or a bench can place a noisy wire model between the two. Two counters are visible at the ports: attempts for the current flit, and the running total of resends.

The sender state machine has three states:
- `TX_IDLE`: ready for a payload. A handshake loads the flit and moves to `TX_SEND`.
- `TX_SEND`: the flit is on the channel for one cycle. The state then always moves to `TX_WAIT`.
- `TX_WAIT`: waiting for the receiver's answer. An acknowledge moves to `TX_IDLE`. A resend request moves to `TX_SEND`. With no answer, the state stays in `TX_WAIT`.

Top module: `arq_flit_link`

## Requirements
- R1: A synchronous active-high reset, even in the middle of a transfer, returns the sender to idle and clears all state. After reset, `in_ready` is 1, and `tx_chan_valid`, `out_valid`, `flit_tries` and `retx_total` are all 0.
- R2: The channel word is 40 bits. Bits 39:8 carry the payload, and bits 7:0 carry the XOR of payload bytes 31:24, 23:16, 15:8 and 7:0.
- R3: `in_ready` is 1 only in `TX_IDLE`. While a flit is outstanding, payloads offered on `in_valid`/`in_data` are ignored, and the held flit does not change.
- R4: Each attempt raises `tx_chan_valid` for exactly one cycle. Every retry carries the same channel word as the first attempt.
- R5: A received flit whose check byte does not match is never delivered and produces a resend request. A matching flit is delivered exactly once, with its payload on `out_data`.
- R6: After every resend request, the sender transmits the flit again, without limit. `flit_tries` reads 1 after the flit is accepted and rises by one with every resend.
- R7: `retx_total` counts every resend request since reset, across flits.
- R8: An error pattern that flips an even number of bits in every bit column of the five channel bytes cannot be detected. Such a flit is delivered with the altered payload on its first attempt.
- R9: A flit that appears on the channel in cycle n is answered, and if clean delivered, in cycle n+2. The sender takes the next step in cycle n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload offered |
| in_ready | output | 1 | Sender is idle and takes a payload |
| in_data | input | DATA_W | Payload to send |
| tx_chan_valid | output | 1 | Channel word driven this cycle |
| tx_chan_data | output | DATA_W+CHK_W | Channel word leaving the sender |
| rx_chan_valid | input | 1 | Channel word arriving at the receiver |
| rx_chan_data | input | DATA_W+CHK_W | Channel word arriving at the receiver |
| out_valid | output | 1 | Clean payload delivered |
| out_data | output | DATA_W | Delivered payload |
| flit_tries | output | CNT_W | Attempts for the current flit |
| retx_total | output | CNT_W | Resend requests since reset |

## Verification
The bench builds the block with its defaults: a 32-bit payload, an 8-bit check and 16-bit counters. This gives four byte columns folded into one check byte, so a two-bit flip that cancels within a column can be placed on the wire to exercise R8. The 16-bit counters cannot wrap within the bench, so the cumulative resend count can be compared exactly. The bench places an XOR error mask between the channel ports. With it, the bench corrupts a chosen number of attempts per flit, up to five in a row, hitting payload bits, check bits and whole bytes, and then lets a clean copy through.

// File: rtl/arq_link_pkg.sv
package arq_link_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SEND,
        TX_WAIT
    } tx_state_e;
endpackage

// File: rtl/arq_fold_check.sv
// Parallel check byte for generator x^8+1: XOR of all CHK_W-wide payload slices.
module arq_fold_check #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    localparam int NSLICE = DATA_W / CHK_W;

    always_comb begin
        chk = '0;
        for (int i = 0; i < NSLICE; i++) begin
            chk = chk ^ data[i*CHK_W +: CHK_W];
        end
    end
endmodule

// File: rtl/arq_tx.sv
module arq_tx
    import arq_link_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    chan_valid,
    output logic [DATA_W+CHK_W-1:0] chan_data,
    input  logic                    rsp_valid,
    input  logic                    rsp_ack,
    output logic [CNT_W-1:0]        flit_tries,
    output logic [CNT_W-1:0]        retx_total
);
    localparam int FLIT_W = DATA_W + CHK_W;

    tx_state_e          state_q, state_d;
    logic [FLIT_W-1:0]  hold_q;
    logic [CNT_W-1:0]   tries_q, retx_q;
    logic [CHK_W-1:0]   enc_chk;
    logic               take, nack;

    arq_fold_check #(.DATA_W(DATA_W), .CHK_W(CHK_W)) enc_i (
        .data (in_data),
        .chk  (enc_chk)
    );

    assign take = (state_q == TX_IDLE) && in_valid;
    assign nack = (state_q == TX_WAIT) && rsp_valid && !rsp_ack;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (in_valid) state_d = TX_SEND;
            TX_SEND: state_d = TX_WAIT;
            TX_WAIT: if (rsp_valid) state_d = rsp_ack ? TX_IDLE : TX_SEND;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            tries_q <= '0;
            retx_q  <= '0;
        end else begin
            if (take) begin
                hold_q  <= {in_data, enc_chk};
                tries_q <= CNT_W'(1);
            end
            if (nack) begin
                tries_q <= tries_q + 1'b1;
                retx_q  <= retx_q + 1'b1;
            end
        end
    end

    always_comb begin
        in_ready   = (state_q == TX_IDLE);
        chan_valid = (state_q == TX_SEND);
        chan_data  = hold_q;
        flit_tries = tries_q;
        retx_total = retx_q;
    end

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != TX_IDLE) |=> $stable(hold_q));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chan_valid |=> !chan_valid);

    // R6
    nack_resend_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_WAIT && rsp_valid && !rsp_ack) |=> (state_q == TX_SEND));

    // R7
    retx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack) |=> (retx_total == CNT_W'($past(retx_total) + 1'b1)));
endmodule

// File: rtl/arq_rx.sv
module arq_rx #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    chan_valid,
    input  logic [DATA_W+CHK_W-1:0] chan_data,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic                    rsp_valid,
    output logic                    rsp_ack
);
    localparam int FLIT_W = DATA_W + CHK_W;

    logic               cap_valid_q;
    logic [FLIT_W-1:0]  cap_data_q;
    logic [CHK_W-1:0]   calc_chk;
    logic               good;

    arq_fold_check #(.DATA_W(DATA_W), .CHK_W(CHK_W)) dec_i (
        .data (cap_data_q[FLIT_W-1:CHK_W]),
        .chk  (calc_chk)
    );

    assign good = (calc_chk == cap_data_q[CHK_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid_q <= 1'b0;
            cap_data_q  <= '0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            rsp_valid   <= 1'b0;
            rsp_ack     <= 1'b0;
        end else begin
            cap_valid_q <= chan_valid;
            cap_data_q  <= chan_data;
            out_valid   <= cap_valid_q && good;
            rsp_valid   <= cap_valid_q;
            rsp_ack     <= cap_valid_q && good;
            if (cap_valid_q && good) out_data <= cap_data_q[FLIT_W-1:CHK_W];
        end
    end

    // R9
    answer_latency_chk: assert property (@(posedge clk) disable iff (rst)
        chan_valid |-> ##2 rsp_valid);

    // R5
    no_bad_delivery_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rsp_valid && rsp_ack));
endmodule

// File: rtl/arq_flit_link.sv
module arq_flit_link #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [DATA_W-1:0]       in_data,
    output logic                    tx_chan_valid,
    output logic [DATA_W+CHK_W-1:0] tx_chan_data,
    input  logic                    rx_chan_valid,
    input  logic [DATA_W+CHK_W-1:0] rx_chan_data,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic [CNT_W-1:0]        flit_tries,
    output logic [CNT_W-1:0]        retx_total
);
    logic rsp_valid, rsp_ack;

    arq_tx #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .chan_valid (tx_chan_valid),
        .chan_data  (tx_chan_data),
        .rsp_valid  (rsp_valid),
        .rsp_ack    (rsp_ack),
        .flit_tries (flit_tries),
        .retx_total (retx_total)
    );

    arq_rx #(.DATA_W(DATA_W), .CHK_W(CHK_W)) rx_i (
        .clk        (clk),
        .rst        (rst),
        .chan_valid (rx_chan_valid),
        .chan_data  (rx_chan_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .rsp_valid  (rsp_valid),
        .rsp_ack    (rsp_ack)
    );
endmodule

// File: tb/arq_flit_link_tb.sv
module arq_flit_link_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NROW = 7;

    // payload, corrupted attempts, mask for those, mask for the final attempt,
    // expected delivered payload, cumulative resends afterwards
    localparam logic [31:0] T_DATA [NROW] = '{32'h00000000, 32'hDEADBEEF, 32'h12345678,
        32'hFFFFFFFF, 32'hA5A55A5A, 32'h0F0FF0F0, 32'h11223344};
    localparam int T_BAD [NROW] = '{0, 1, 3, 2, 5, 0, 1};
    localparam logic [39:0] T_BMASK [NROW] = '{40'h0, 40'h8000000000, 40'h0000000001,
        40'h0000000007, 40'h0000FF0000, 40'h0, 40'h8000000000};
    localparam logic [39:0] T_LMASK [NROW] = '{40'h0, 40'h0, 40'h0, 40'h0, 40'h0, 40'h0,
        40'h0000010100};
    localparam logic [31:0] T_EXP [NROW] = '{32'h00000000, 32'hDEADBEEF, 32'h12345678,
        32'hFFFFFFFF, 32'hA5A55A5A, 32'h0F0FF0F0, 32'h11223245};
    localparam int T_RETX [NROW] = '{0, 1, 4, 6, 11, 11, 12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, tx_chan_valid, out_valid;
    logic [39:0] tx_chan_data, rx_chan_data;
    logic [39:0] mask = '0;
    logic [31:0] out_data;
    logic [15:0] flit_tries, retx_total;
    int n_chk = 0, n_err = 0, n_deliv = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_chan_data = tx_chan_data ^ mask;

    arq_flit_link dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .tx_chan_valid(tx_chan_valid), .tx_chan_data(tx_chan_data),
        .rx_chan_valid(tx_chan_valid), .rx_chan_data(rx_chan_data),
        .out_valid(out_valid), .out_data(out_data),
        .flit_tries(flit_tries), .retx_total(retx_total)
    );

    always @(negedge clk) if (!rst && out_valid) n_deliv++;

    function automatic logic [7:0] fold(input logic [31:0] d);
        return d[31:24] ^ d[23:16] ^ d[15:8] ^ d[7:0];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_flit(input logic [31:0] d, input int nbad, input logic [39:0] bm,
                            input logic [39:0] lm, input logic [31:0] exp, input int retx);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        check("R3 ready while idle", in_ready, 1);
        @(negedge clk);
        in_valid = 1'b0;
        for (int a = 0; a <= nbad; a++) begin
            check("R4 attempt on channel", tx_chan_valid, 1);
            check("R2 flit layout, R4 same word", tx_chan_data, {d, fold(d)});
            check("R3 not ready while busy", in_ready, 0);
            mask = (a < nbad) ? bm : lm;
            @(negedge clk);
            mask = '0;
            check("R4 one-cycle pulse", tx_chan_valid, 0);
            in_valid = 1'b1;
            in_data  = ~d;
            @(negedge clk);
            in_valid = 1'b0;
            check("R5 R9 delivery only when clean", out_valid, (a == nbad));
            if (a == nbad) check("R5 R8 delivered payload", out_data, exp);
            check("R6 attempt count", flit_tries, a + 1);
            @(negedge clk);
        end
        check("R6 back to idle after ack", in_ready, 1);
        check("R6 final attempt count", flit_tries, nbad + 1);
        check("R7 resend total", retx_total, retx);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset ready", in_ready, 1);
        check("R1 reset channel idle", tx_chan_valid, 0);
        check("R1 reset no delivery", out_valid, 0);
        check("R1 reset tries", flit_tries, 0);
        check("R1 reset resends", retx_total, 0);
        rst = 1'b0;

        for (int r = 0; r < NROW; r++)
            run_flit(T_DATA[r], T_BAD[r], T_BMASK[r], T_LMASK[r], T_EXP[r], T_RETX[r]);
        check("R5 exactly one delivery per flit", n_deliv, NROW);

        // R1: reset while waiting for the answer
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'hCAFEF00D;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-flight reset ready", in_ready, 1);
        check("R1 mid-flight reset channel", tx_chan_valid, 0);
        check("R1 mid-flight reset tries", flit_tries, 0);
        check("R1 mid-flight reset resends", retx_total, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 dropped flit not delivered", n_deliv, NROW);
        check("R1 dropped flit not resent", tx_chan_valid, 0);
        run_flit(32'h5555AAAA, 1, 40'h0000000080, 40'h0, 32'h5555AAAA, 1);
        check("R5 delivery count after reset", n_deliv, NROW + 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule